// File: doc/BRIEF.md
# Octet-Handshake ATM Cell Receiver

This block is the receive side of an 8-bit cell interface that uses octet-level handshaking. On every rising edge of the receive clock it samples a data byte, a start-of-cell strobe and an active-low data-available input from the line-side device. It drives an active-low enable that tells the device when bytes may be transferred. A byte counts only on an edge that follows a cycle in which the enable was low, and only if the device also flagged data available on that edge. The block aligns to cells on the start-of-cell strobe and treats every 53 counted bytes as one complete cell.

Only complete cells are written into an internal store. The store holds `DEPTH` cells and is drained one byte at a time through a read port with valid, ready and a first-byte marker. A configuration bit selects what happens when the store is full. With the bit clear, the enable stays low and any cell that starts while no slot is free is thrown away whole. A sticky overrun flag and a saturating drop counter record each such loss. With the bit set, the enable rises together with the last byte that fits. It then stays high until every stored cell has been read out.

Top module: `utrx_cell_rx`

## Requirements
- R1: While reset is applied, `rx_enb_n` is 1, `rd_valid` is 0, `overrun` is 0 and `drop_count` is 0. On the first clock edge after reset is released, `rx_enb_n` goes to 0.
- R2: A byte is taken on a rising edge only if `rx_enb_n` was 0 during the cycle before that edge and `rx_empty_n` is 1 on that edge. On edges where `rx_empty_n` is 0, neither `rx_data` nor `rx_soc` has any effect.
- R3: With `cfg_nodrop` = 0, `rx_enb_n` stays 0 at all times after the first edge following reset, including while the store is full.
- R4: A taken byte with `rx_soc` = 1 is byte 1 of a new cell. On the edge that takes byte 53, the cell enters the store, and `rd_valid` is 1 after that edge and not before it. Taken bytes that arrive outside a cell, before any start-of-cell or after a completed cell, are ignored.
- R5: If a start-of-cell is taken before byte 53 of the current cell, the partial cell is discarded and counting restarts with that byte as byte 1. A partial cell never reaches the read port.
- R6: The read port presents stored cells in arrival order. Each cell is 53 bytes in the order they were taken, and `rd_sop` = 1 only on its first byte. A byte is consumed on an edge with `rd_valid` = 1 and `rd_ready` = 1. The store holds `DEPTH` cells.
- R7: With `cfg_nodrop` = 0, a cell whose start-of-cell is taken while `DEPTH` cells are stored is dropped whole and its bytes never appear at the read port. When its 53rd byte is taken, `overrun` becomes 1 and stays 1 until reset, and `drop_count` increases by one, saturating at all ones.
- R8: With `cfg_nodrop` = 1, `rx_enb_n` rises on the edge that takes byte 53 of the cell that fills the last free slot. No byte offered afterwards is taken while it is high.
- R9: With `cfg_nodrop` = 1, once `rx_enb_n` is high it stays high until the store is completely empty. It returns to 0 on the edge that consumes the final byte of the last stored cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_nodrop | input | 1 | Full-store policy: 0 drops whole cells, 1 applies flow control |
| rx_data | input | 8 | Receive data byte from the line-side device |
| rx_soc | input | 1 | High together with the first header byte of a cell |
| rx_empty_n | input | 1 | Active low: 0 means the device has no valid byte on this edge |
| rx_enb_n | output | 1 | Active-low enable requesting bytes from the device |
| rd_data | output | 8 | Byte at the head of the cell store |
| rd_sop | output | 1 | Marks the first byte of a stored cell |
| rd_valid | output | 1 | A stored byte is available |
| rd_ready | input | 1 | Consumer accepts the presented byte |
| overrun | output | 1 | Sticky: a cell was lost because the store was full |
| drop_count | output | CNT_W | Saturating count of dropped cells |

## Verification
The bench interleaves unavailable cycles that carry junk data and a junk start-of-cell strobe. A receiver that latched on those edges would corrupt the payload or realign mid-cell. It also aborts partial cells anywhere from one byte long up to 52 bytes long, which catches a counter that fails to restart or that lets a fragment leak into the store. The store is overfilled in drop mode, so a design that drops only part of a cell, or that overwrites a stored cell, shows up as corrupt read data or wrong counters. In flow-controlled mode the bench keeps offering a full cell while the enable is high, then checks that the enable stays high until the very last byte is drained. A design that took bytes while disabled, or that released the enable early, would bump the drop counter or show the wrong enable level.

// File: rtl/utrx_pkg.sv
package utrx_pkg;
    localparam int CELL_BYTES = 53;
    localparam int OFF_W      = $clog2(CELL_BYTES);
    typedef logic [7:0] octet_t;
endpackage

// File: rtl/utrx_framer.sv
module utrx_framer #(
    parameter int CELL_BYTES = 53
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          accept,
    input  logic                          rx_soc,
    input  logic                          store_full,
    output logic                          wr_en,
    output logic [$clog2(CELL_BYTES)-1:0] wr_off,
    output logic                          commit,
    output logic                          drop_done
);
    localparam int OW = $clog2(CELL_BYTES);

    typedef struct packed {
        logic          in_cell;
        logic          dropping;
        logic [OW-1:0] cnt;
    } frm_t;

    frm_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        wr_en     = 1'b0;
        wr_off    = s_q.cnt;
        commit    = 1'b0;
        drop_done = 1'b0;
        if (accept) begin
            if (rx_soc) begin
                s_d.in_cell  = 1'b1;
                s_d.dropping = store_full;
                s_d.cnt      = OW'(1);
                wr_en        = !store_full;
                wr_off       = '0;
            end else if (s_q.in_cell) begin
                wr_en = !s_q.dropping;
                if (s_q.cnt == OW'(CELL_BYTES - 1)) begin
                    s_d.in_cell = 1'b0;
                    s_d.cnt     = '0;
                    commit      = !s_q.dropping;
                    drop_done   = s_q.dropping;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/utrx_cell_store.sv
module utrx_cell_store #(
    parameter int DEPTH      = 4,
    parameter int CELL_BYTES = 53
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(CELL_BYTES)-1:0] wr_off,
    input  logic [7:0]                    wr_data,
    input  logic                          commit,
    input  logic                          rd_ready,
    output logic [7:0]                    rd_data,
    output logic                          rd_sop,
    output logic                          rd_valid,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    used_nx
);
    localparam int OW    = $clog2(CELL_BYTES);
    localparam int UW    = $clog2(DEPTH + 1);
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int MEM_N = DEPTH * CELL_BYTES;
    localparam int AW    = $clog2(MEM_N);

    typedef struct packed {
        logic [PW-1:0] wr_slot;
        logic [PW-1:0] rd_slot;
        logic [OW-1:0] rd_off;
        logic [UW-1:0] used;
    } sto_t;

    sto_t s_d, s_q;
    utrx_pkg::octet_t mem [MEM_N];

    logic [PW-1:0] wr_next, rd_next;
    logic          pop_byte, pop_cell;
    logic [AW-1:0] wr_addr, rd_addr;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            assign wr_next = s_q.wr_slot + 1'b1;
            assign rd_next = s_q.rd_slot + 1'b1;
        end else begin : g_wrap
            assign wr_next = (s_q.wr_slot == PW'(DEPTH - 1)) ? '0 : s_q.wr_slot + 1'b1;
            assign rd_next = (s_q.rd_slot == PW'(DEPTH - 1)) ? '0 : s_q.rd_slot + 1'b1;
        end
    endgenerate

    assign wr_addr  = AW'(s_q.wr_slot) * AW'(CELL_BYTES) + AW'(wr_off);
    assign rd_addr  = AW'(s_q.rd_slot) * AW'(CELL_BYTES) + AW'(s_q.rd_off);
    assign rd_valid = (s_q.used != '0);
    assign rd_data  = mem[rd_addr];
    assign rd_sop   = (s_q.rd_off == '0);
    assign full     = (s_q.used == UW'(DEPTH));
    assign pop_byte = rd_valid && rd_ready;
    assign pop_cell = pop_byte && (s_q.rd_off == OW'(CELL_BYTES - 1));
    assign used_nx  = s_d.used;

    always_comb begin
        s_d = s_q;
        if (commit) s_d.wr_slot = wr_next;
        if (pop_byte) begin
            if (pop_cell) begin
                s_d.rd_off  = '0;
                s_d.rd_slot = rd_next;
            end else begin
                s_d.rd_off = s_q.rd_off + 1'b1;
            end
        end
        case ({commit, pop_cell})
            2'b10:   s_d.used = s_q.used + 1'b1;
            2'b01:   s_d.used = s_q.used - 1'b1;
            default: s_d.used = s_q.used;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end
endmodule

// File: rtl/utrx_flow_ctl.sv
module utrx_flow_ctl #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cfg_nodrop,
    input  logic [$clog2(DEPTH+1)-1:0] used_nx,
    input  logic                       drop_done,
    output logic                       rx_enb_n,
    output logic                       overrun,
    output logic [CNT_W-1:0]           drop_count
);
    localparam int UW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic             enb_n;
        logic             ovr;
        logic [CNT_W-1:0] drops;
    } flw_t;

    flw_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.enb_n = cfg_nodrop &&
                    ((used_nx == UW'(DEPTH)) || (s_q.enb_n && (used_nx != '0)));
        if (drop_done) begin
            s_d.ovr = 1'b1;
            if (s_q.drops != '1) s_d.drops = s_q.drops + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.enb_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_enb_n   = s_q.enb_n;
    assign overrun    = s_q.ovr;
    assign drop_count = s_q.drops;
endmodule

// File: rtl/utrx_cell_rx.sv
module utrx_cell_rx #(
    parameter int DEPTH = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_nodrop,
    input  logic [7:0]       rx_data,
    input  logic             rx_soc,
    input  logic             rx_empty_n,
    output logic             rx_enb_n,
    output logic [7:0]       rd_data,
    output logic             rd_sop,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             overrun,
    output logic [CNT_W-1:0] drop_count
);
    localparam int OW = utrx_pkg::OFF_W;
    localparam int UW = $clog2(DEPTH + 1);

    logic          accept;
    logic          wr_en, commit, drop_done, store_full;
    logic [OW-1:0] wr_off;
    logic [UW-1:0] used_nx;

    assign accept = !rx_enb_n && rx_empty_n;

    utrx_framer #(.CELL_BYTES(utrx_pkg::CELL_BYTES)) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .rx_soc     (rx_soc),
        .store_full (store_full),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .commit     (commit),
        .drop_done  (drop_done)
    );

    utrx_cell_store #(.DEPTH(DEPTH), .CELL_BYTES(utrx_pkg::CELL_BYTES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_off   (wr_off),
        .wr_data  (rx_data),
        .commit   (commit),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_sop   (rd_sop),
        .rd_valid (rd_valid),
        .full     (store_full),
        .used_nx  (used_nx)
    );

    utrx_flow_ctl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flow (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_nodrop (cfg_nodrop),
        .used_nx    (used_nx),
        .drop_done  (drop_done),
        .rx_enb_n   (rx_enb_n),
        .overrun    (overrun),
        .drop_count (drop_count)
    );
endmodule

// File: rtl/utrx_rx_checker.sv
module utrx_rx_checker #(
    parameter int CELL_BYTES = 53,
    parameter int CNT_W      = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_nodrop,
    input logic             rx_empty_n,
    input logic             rx_enb_n,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic             rd_sop,
    input logic             overrun,
    input logic [CNT_W-1:0] drop_count
);
    localparam int OW = $clog2(CELL_BYTES);

    logic [OW-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else if (rd_valid && rd_ready)
            pcnt_q <= (pcnt_q == OW'(CELL_BYTES - 1)) ? '0 : pcnt_q + 1'b1;
    end

    AST_DROP_MODE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(cfg_nodrop) |-> !rx_enb_n); // R3
    AST_CELL_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> $past(!rx_enb_n && rx_empty_n)); // R2
    AST_SOP_FRAMING: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |-> (rd_sop == (pcnt_q == '0))); // R6
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid); // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(overrun) |-> overrun); // R7
    AST_DROP_COUNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> drop_count >= $past(drop_count)); // R7
    AST_NODROP_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_nodrop && $past(cfg_nodrop) && $past(rst_n) && $fell(rx_enb_n) |-> !rd_valid); // R9
endmodule

bind utrx_cell_rx utrx_rx_checker #(
    .CELL_BYTES (utrx_pkg::CELL_BYTES),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_nodrop (cfg_nodrop),
    .rx_empty_n (rx_empty_n),
    .rx_enb_n   (rx_enb_n),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_sop     (rd_sop),
    .overrun    (overrun),
    .drop_count (drop_count)
);

// File: tb/sim_utrx_cell_rx.sv
`timescale 1ns/1ps
module sim_utrx_cell_rx;
    localparam int DEPTH = 4;
    localparam int CNT_W = 8;
    localparam int NB    = 53;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_nodrop = 1'b0;
    logic [7:0]       rx_data = 8'h00;
    logic             rx_soc = 1'b0;
    logic             rx_empty_n = 1'b0;
    logic             rx_enb_n;
    logic [7:0]       rd_data;
    logic             rd_sop, rd_valid;
    logic             rd_ready = 1'b0;
    logic             overrun;
    logic [CNT_W-1:0] drop_count;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    utrx_cell_rx #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (.*);

    typedef struct packed {
        logic [7:0] seed;
        logic [1:0] gap;
        logic [5:0] abort_len;
        logic [2:0] junk;
        logic [7:0] exp_first;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h10, 2'd0, 6'd0,  3'd0, 8'h10},
        '{8'h40, 2'd1, 6'd0,  3'd2, 8'h40},
        '{8'h77, 2'd3, 6'd5,  3'd0, 8'h77},
        '{8'hA0, 2'd0, 6'd52, 3'd0, 8'hA0},
        '{8'hC3, 2'd2, 6'd1,  3'd3, 8'hC3},
        '{8'hF0, 2'd0, 6'd0,  3'd1, 8'hF0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic [7:0] d, input logic soc);
        logic taken;
        taken = 1'b0;
        while (!taken) begin
            @(negedge clk);
            rx_data = d; rx_soc = soc; rx_empty_n = 1'b1;
            taken = !rx_enb_n;
            @(posedge clk);
            #1;
            rx_empty_n = 1'b0; rx_soc = 1'b0;
        end
    endtask

    task automatic put_raw(input logic [7:0] d, input logic soc);
        @(negedge clk);
        rx_data = d; rx_soc = soc; rx_empty_n = 1'b1;
        @(posedge clk);
        #1;
        rx_empty_n = 1'b0; rx_soc = 1'b0;
    endtask

    task automatic gap_cycle();
        @(negedge clk);
        rx_data = 8'h5A; rx_soc = 1'b1; rx_empty_n = 1'b0;
        @(posedge clk);
        #1;
        rx_soc = 1'b0;
    endtask

    task automatic send_cell(input logic [7:0] seed, input int gap, input bit early_chk);
        for (int i = 0; i < NB; i++) begin
            if (i == NB - 1 && early_chk) begin
                @(negedge clk);
                chk("R4 not valid before byte 53", {31'd0, rd_valid}, 32'd0);
            end
            put_byte(seed + 8'(i), i == 0);
            for (int g = 0; g < gap; g++) gap_cycle();
        end
    endtask

    task automatic read_cell(input logic [7:0] first, input string req);
        for (int i = 0; i < NB; i++) begin
            @(negedge clk);
            rd_ready = 1'b1;
            chk(req, {22'd0, rd_valid, rd_sop, rd_data},
                {22'd0, 1'b1, (i == 0), first + 8'(i)});
            @(posedge clk);
            #1;
            rd_ready = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 enb_n in reset", {31'd0, rx_enb_n}, 32'd1);
        chk("R1 rd_valid in reset", {31'd0, rd_valid}, 32'd0);
        chk("R1 overrun in reset", {31'd0, overrun}, 32'd0);
        chk("R1 drop_count in reset", {24'd0, drop_count}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 enb_n low after first edge", {31'd0, rx_enb_n}, 32'd0);

        // Table: drop mode, single cells with gaps (R2), junk (R4), aborts (R5)
        foreach (VECS[k]) begin
            for (int j = 0; j < int'(VECS[k].junk); j++) put_byte(8'hEE, 1'b0);
            for (int j = 0; j < int'(VECS[k].abort_len); j++) put_byte(8'hE0 ^ 8'(j), j == 0);
            send_cell(VECS[k].seed, int'(VECS[k].gap), 1'b1);
            @(negedge clk);
            chk("R4 valid after byte 53", {31'd0, rd_valid}, 32'd1);
            chk("R3 enb_n low in drop mode", {31'd0, rx_enb_n}, 32'd0);
            read_cell(VECS[k].exp_first, "R2 R5 R6 table cell data");
            @(negedge clk);
            chk("R5 no partial cell left", {31'd0, rd_valid}, 32'd0);
        end

        // Drop mode overfill: R3, R6, R7
        for (int c = 1; c <= DEPTH; c++) send_cell(8'(c * 16), 0, c == 1);
        @(negedge clk);
        chk("R3 enb_n low with store full", {31'd0, rx_enb_n}, 32'd0);
        send_cell(8'h55, 0, 1'b0);
        @(negedge clk);
        chk("R7 overrun set", {31'd0, overrun}, 32'd1);
        chk("R7 drop_count one", {24'd0, drop_count}, 32'd1);
        for (int c = 1; c <= DEPTH; c++) read_cell(8'(c * 16), "R6 R7 order after drop");
        @(negedge clk);
        chk("R7 dropped cell absent", {31'd0, rd_valid}, 32'd0);
        send_cell(8'h66, 1, 1'b1);
        read_cell(8'h66, "R7 recovery cell");
        @(negedge clk);
        chk("R7 overrun sticky", {31'd0, overrun}, 32'd1);

        // Flow-controlled mode: R8, R9, R2
        cfg_nodrop = 1'b1;
        for (int c = 1; c < DEPTH; c++) send_cell(8'(8'h80 + c), 0, 1'b0);
        @(negedge clk);
        chk("R8 enb_n low with free slot", {31'd0, rx_enb_n}, 32'd0);
        for (int i = 0; i < NB; i++) begin
            if (i == NB - 1) begin
                @(negedge clk);
                chk("R8 enb_n low before last byte", {31'd0, rx_enb_n}, 32'd0);
            end
            put_byte(8'h90 + 8'(i), i == 0);
        end
        @(negedge clk);
        chk("R8 enb_n high after filling byte", {31'd0, rx_enb_n}, 32'd1);
        for (int i = 0; i < NB; i++) put_raw(8'h33, i == 0);
        chk("R2 R8 no byte taken while disabled", {24'd0, drop_count}, 32'd1);
        for (int c = 1; c < DEPTH; c++) begin
            read_cell(8'(8'h80 + c), "R9 cell data");
            @(negedge clk);
            chk("R9 enb_n held until empty", {31'd0, rx_enb_n}, 32'd1);
        end
        read_cell(8'h90, "R9 last cell data");
        @(negedge clk);
        chk("R9 enb_n low once empty", {31'd0, rx_enb_n}, 32'd0);
        chk("R9 store empty", {31'd0, rd_valid}, 32'd0);
        send_cell(8'h21, 0, 1'b1);
        read_cell(8'h21, "R9 receive after release");

        finish_run();
    end
endmodule